// File: doc/BRIEF.md
# Temperature-Indexed Table Compensation Sequencer

This block turns each new temperature reading into per-channel control values. When a conversion finishes, it takes the signed temperature word and converts it into a table pointer. The pointer has 4 °C steps below 56 °C and 2 °C steps from 56 °C upward. When the temperature has dropped since the last reading, 1 °C of hysteresis is added. A coarse offset-table pointer with 16 °C steps is derived from the same pointer.

For every enabled channel, the block reads one offset byte and one table byte through a shared synchronous memory port. It forms table + 4 × offset, keeps 10 bits, and emits a write of that value left-justified into a 16-bit channel value register. A host can freeze the pointer and supply its own. A bus-busy flag holds the sequencer back whenever the host owns the shared memory.

Top module: `tlut_comp`

## Requirements
- R1: `temp_in` is signed two's complement in 1/16 °C steps, left-justified in 16 bits with bits [3:0] zero. For an effective temperature T with −40 °C ≤ T < 56 °C, the pointer is 80h + floor((T + 40)/4). Example: 43 °C gives 94h and −36 °C gives 81h.
- R2: For 56 °C ≤ T < 102 °C, the pointer is 80h + floor((T − 8)/2). T ≥ 102 °C gives AFh. T < −40 °C gives 80h.
- R3: The offset address is derived from the pointer P: F8h when P < 88h, F9h + (P − 88h)/4 when P < 98h, and otherwise FDh + (P − 98h)/8 capped at FFh. In temperature terms this is F8h below −8 °C, one slot per 16 °C above that, and FFh from 88 °C.
- R4: A channel's write data is ((lut + 4 × offset) mod 1024) × 64. Bits lost to overflow are dropped.
- R5: The effective temperature is the reading plus 1 °C when the reading is lower than the previous reading used for a pointer, and equals the reading otherwise. The first conversion after reset uses no hysteresis.
- R6: Only channels whose `chan_en` bit is set get a `val_we` strobe. A channel with its bit clear gets no write and no memory reads.
- R7: With `auto_idx` = 0, the computed pointer is discarded and `user_idx` is loaded into `idx_out`. Memory addresses use `user_idx` with bit 7 forced to 1. Every memory address has bit 7 set.
- R8: While `bus_busy` is high, no conversion starts and no channel's memory access begins. A conversion that arrives during a busy period is processed once the bus is released.
- R9: `done` pulses for one cycle after the last channel is handled, exactly once per conversion, even when no channel is enabled.
- R10: After reset, `idx_out` = 80h and `mem_rd`, `val_we` and `done` are 0.
- R11: Each enabled channel, in ascending channel order, reads its offset byte and then its table byte, with `mem_tbl` = channel number. Read data returns one cycle after `mem_rd`. The write follows the two reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| temp_in | input | 16 | Temperature word, 1/16 °C, left-justified |
| conv_done | input | 1 | One-cycle strobe: new temperature valid |
| chan_en | input | NCH | Per-channel automatic update enable |
| auto_idx | input | 1 | 1: computed pointer, 0: host pointer |
| user_idx | input | 8 | Host-written pointer |
| bus_busy | input | 1 | Host owns the shared memory |
| mem_rd | output | 1 | Memory read request |
| mem_tbl | output | CHW | Table (channel) select for the read |
| mem_addr | output | 8 | Byte address within the table |
| mem_rdata | input | 8 | Read data, one cycle after the request |
| val_we | output | 1 | Channel value write strobe |
| val_ch | output | CHW | Channel being written |
| val_data | output | 16 | Left-justified 10-bit result |
| idx_out | output | 8 | Current pointer register |
| done | output | 1 | One-cycle pulse after all channels |

## Verification
The embedded properties check the following on every cycle:
- after a stall decision with the bus busy, no read is issued;
- every address lies in the upper half of the table;
- an automatic pointer stays within 80h–AFh;
- a host pointer is copied verbatim;
- read, write and completion strobes never overlap;
- each write comes two cycles after a read.

Only the directed scenarios can show the rest:
- exact pointer and offset values on each side of 56 °C, at the clamps, and with hysteresis on falling temperature;
- the arithmetic, including 10-bit wrap;
- that disabled channels are skipped;
- that a conversion held back by the busy flag is still completed.

// File: rtl/tlut_comp.sv
module tlut_comp #(
  parameter int NCH = 4,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [15:0]     temp_in,
  input  logic            conv_done,
  input  logic [NCH-1:0]  chan_en,
  input  logic            auto_idx,
  input  logic [7:0]      user_idx,
  input  logic            bus_busy,
  output logic            mem_rd,
  output logic [CHW-1:0]  mem_tbl,
  output logic [7:0]      mem_addr,
  input  logic [7:0]      mem_rdata,
  output logic            val_we,
  output logic [CHW-1:0]  val_ch,
  output logic [15:0]     val_data,
  output logic [7:0]      idx_out,
  output logic            done
);

  typedef enum logic [2:0] {
    S_IDLE, S_INDEX, S_SEL, S_ROFF, S_RLUT, S_WAIT, S_WRITE, S_DONE
  } st_t;

  st_t                st;
  logic               pend;
  logic signed [11:0] temp_q;
  logic signed [11:0] prev_q;
  logic               prev_v;
  logic [7:0]         idx_q;
  logic [CHW-1:0]     ch_q;
  logic [7:0]         off_q;
  logic [9:0]         sum_q;

  logic               falling;
  logic signed [13:0] t_eff;
  logic signed [13:0] t_sh;
  logic [7:0]         calc_idx;
  logic [7:0]         midx;
  logic [7:0]         d_lo;
  logic [7:0]         d_hi;
  logic [7:0]         off_addr;
  logic               last_ch;

  assign falling = prev_v && (temp_q < prev_q);
  assign t_eff   = {{2{temp_q[11]}}, temp_q} + (falling ? 14'sd16 : 14'sd0);

  always_comb begin
    t_sh = '0;
    if (t_eff < -14'sd640) begin
      calc_idx = 8'h80;
    end else if (t_eff < 14'sd896) begin
      t_sh     = t_eff + 14'sd640;
      calc_idx = 8'h80 + {3'b000, t_sh[10:6]};
    end else if (t_eff < 14'sd1632) begin
      t_sh     = t_eff - 14'sd128;
      calc_idx = 8'h80 + {2'b00, t_sh[10:5]};
    end else begin
      calc_idx = 8'hAF;
    end
  end

  assign midx = {1'b1, idx_q[6:0]};
  assign d_lo = midx - 8'h88;
  assign d_hi = midx - 8'h98;

  always_comb begin
    if (midx < 8'h88)       off_addr = 8'hF8;
    else if (midx < 8'h98)  off_addr = 8'hF9 + {2'b00, d_lo[7:2]};
    else if (d_hi[7:3] > 5'd1) off_addr = 8'hFF;
    else                    off_addr = 8'hFD + {3'b000, d_hi[7:3]};
  end

  assign last_ch = (ch_q == CHW'(NCH - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      pend   <= 1'b0;
      temp_q <= '0;
      prev_q <= '0;
      prev_v <= 1'b0;
      idx_q  <= 8'h80;
      ch_q   <= '0;
      off_q  <= '0;
      sum_q  <= '0;
    end else begin
      if (conv_done) begin
        temp_q <= temp_in[15:4];
        pend   <= 1'b1;
      end else if (st == S_IDLE && pend && !bus_busy) begin
        pend <= 1'b0;
      end

      case (st)
        S_IDLE:  if (pend && !bus_busy) st <= S_INDEX;
        S_INDEX: begin
          idx_q  <= auto_idx ? calc_idx : user_idx;
          prev_q <= temp_q;
          prev_v <= 1'b1;
          ch_q   <= '0;
          st     <= S_SEL;
        end
        S_SEL: if (!bus_busy) begin
          if (chan_en[ch_q]) st <= S_ROFF;
          else if (last_ch)  st <= S_DONE;
          else               ch_q <= ch_q + 1'b1;
        end
        S_ROFF: st <= S_RLUT;
        S_RLUT: begin
          off_q <= mem_rdata;
          st    <= S_WAIT;
        end
        S_WAIT: begin
          sum_q <= {2'b00, mem_rdata} + {off_q, 2'b00};
          st    <= S_WRITE;
        end
        S_WRITE: begin
          if (last_ch) st <= S_DONE;
          else begin
            ch_q <= ch_q + 1'b1;
            st   <= S_SEL;
          end
        end
        S_DONE:  st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign mem_rd   = (st == S_ROFF) || (st == S_RLUT);
  assign mem_tbl  = ch_q;
  assign mem_addr = (st == S_ROFF) ? off_addr : midx;
  assign val_we   = (st == S_WRITE);
  assign val_ch   = ch_q;
  assign val_data = {sum_q, 6'b000000};
  assign idx_out  = idx_q;
  assign done     = (st == S_DONE);

  p_frac_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done |-> temp_in[3:0] == 4'h0);

  p_idx_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_INDEX && auto_idx) |=> (idx_out >= 8'h80 && idx_out <= 8'hAF));

  p_user_idx_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_INDEX && !auto_idx) |=> idx_out == $past(user_idx));

  p_addr_upper_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> mem_addr[7]);

  p_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SEL && bus_busy) |=> !mem_rd);

  p_one_strobe_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({val_we, mem_rd, done}));

  p_wr_after_rd_r11: assert property (@(posedge clk) disable iff (!rst_n)
    val_we |-> $past(mem_rd, 2));

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

// File: tb/sim_tlut_comp.sv
`timescale 1ns/1ps
module sim_tlut_comp;
  localparam int NCH = 4;
  localparam int CHW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] temp_in = '0;
  logic conv_done = 1'b0;
  logic [NCH-1:0] chan_en = '1;
  logic auto_idx = 1'b1;
  logic [7:0] user_idx = '0;
  logic bus_busy = 1'b0;
  logic mem_rd;
  logic [CHW-1:0] mem_tbl;
  logic [7:0] mem_addr;
  logic [7:0] mem_rdata = '0;
  logic val_we;
  logic [CHW-1:0] val_ch;
  logic [15:0] val_data;
  logic [7:0] idx_out;
  logic done;

  always #4 clk = ~clk;

  tlut_comp #(.NCH(NCH)) u0 (
    .clk(clk), .rst_n(rst_n), .temp_in(temp_in), .conv_done(conv_done),
    .chan_en(chan_en), .auto_idx(auto_idx), .user_idx(user_idx),
    .bus_busy(bus_busy), .mem_rd(mem_rd), .mem_tbl(mem_tbl),
    .mem_addr(mem_addr), .mem_rdata(mem_rdata), .val_we(val_we),
    .val_ch(val_ch), .val_data(val_data), .idx_out(idx_out), .done(done)
  );

  int errors = 0;
  int checks = 0;
  bit force_hi = 1'b0;

  function automatic int memf(int t, int a);
    if (force_hi) return 255;
    if (a >= 'hF8) return (a * 3 + t * 11) & 255;
    return (a * 7 + t * 29) & 255;
  endfunction

  always @(posedge clk)
    if (mem_rd) mem_rdata <= 8'(memf(int'(mem_tbl), int'(mem_addr)));

  int rd_n = 0;
  int rd_addr[16];
  int rd_tbl[16];
  int wr_data[NCH];
  bit [NCH-1:0] wr_mask = '0;
  int done_n = 0;

  always @(negedge clk) begin
    if (mem_rd && rd_n < 16) begin
      rd_addr[rd_n] = int'(mem_addr);
      rd_tbl[rd_n]  = int'(mem_tbl);
      rd_n++;
    end
    if (val_we) begin
      wr_data[val_ch] = int'(val_data);
      wr_mask[val_ch] = 1'b1;
    end
    if (done) done_n++;
  end

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  bit have_prev = 1'b0;
  int prev_t = 0;
  int last_te = 0;

  function automatic int exp_idx(int te);
    if (te < -640) return 'h80;
    if (te < 896)  return 'h80 + (te + 640) / 64;
    if (te < 1632) return 'h80 + (te - 128) / 32;
    return 'hAF;
  endfunction

  function automatic int exp_off(int te);
    int s;
    if (te < -128) return 'hF8;
    s = 'hF9 + (te + 128) / 256;
    return (s > 'hFF) ? 'hFF : s;
  endfunction

  function automatic int exp_val(int ch, int ia, int oa);
    return ((memf(ch, ia) + 4 * memf(ch, oa)) % 1024) * 64;
  endfunction

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    have_prev = 1'b0;
    @(negedge clk);
  endtask

  task automatic clear_logs();
    rd_n = 0;
    wr_mask = '0;
    done_n = 0;
  endtask

  task automatic wait_done();
    int n = 0;
    while (done_n == 0 && n < 300) begin
      @(negedge clk);
      n++;
    end
    @(negedge clk);
    chk("R9", "single done pulse", done_n, 1);
  endtask

  task automatic pulse_conv(int t16);
    @(negedge clk);
    temp_in = 16'(t16 * 16);
    conv_done = 1'b1;
    @(negedge clk);
    conv_done = 1'b0;
    last_te = (have_prev && t16 < prev_t) ? t16 + 16 : t16;
    have_prev = 1'b1;
    prev_t = t16;
  endtask

  task automatic run_conv(int t16);
    clear_logs();
    pulse_conv(t16);
    wait_done();
  endtask

  task automatic check_auto(string req);
    int ei = exp_idx(last_te);
    int eo = exp_off(last_te);
    int k = 0;
    chk(req, "pointer", int'(idx_out), ei);
    for (int c = 0; c < NCH; c++) begin
      if (chan_en[c]) begin
        chk("R3", "offset address", rd_addr[k], eo);
        chk("R11", "table address", rd_addr[k + 1], ei);
        chk("R11", "table select", rd_tbl[k], c);
        chk("R4", "write data", wr_data[c], exp_val(c, ei, eo));
        chk("R6", "enabled channel written", int'(wr_mask[c]), 1);
        k += 2;
      end else begin
        chk("R6", "disabled channel untouched", int'(wr_mask[c]), 0);
      end
    end
    chk("R11", "read count", rd_n, k);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R10", "reset pointer", int'(idx_out), 'h80);
    chk("R10", "reset mem_rd", int'(mem_rd), 0);
    chk("R10", "reset val_we", int'(val_we), 0);
    chk("R10", "reset done", int'(done), 0);
  endtask

  task automatic t_low_band();
    chan_en = 4'hF;
    run_conv(43 * 16);
    chk("R1", "43C pointer literal", int'(idx_out), 'h94);
    chk("R3", "43C offset literal", rd_addr[0], 'hFC);
    check_auto("R1");
    run_conv(-40 * 16 + 8);
    check_auto("R1");
    run_conv(-36 * 16);
    chk("R1", "-36C pointer", int'(idx_out), 'h81);
    check_auto("R1");
  endtask

  task automatic t_high_band_hyst();
    run_conv(70 * 16);
    chk("R2", "70C pointer", int'(idx_out), 'h9F);
    check_auto("R2");
    run_conv(70 * 16 - 8);
    chk("R5", "69.5C falling holds", int'(idx_out), 'h9F);
    check_auto("R5");
    run_conv(68 * 16 + 8);
    chk("R5", "68.5C falling steps", int'(idx_out), 'h9E);
    check_auto("R5");
  endtask

  task automatic t_clamp();
    run_conv(120 * 16);
    chk("R2", "high clamp", int'(idx_out), 'hAF);
    check_auto("R2");
    run_conv(-55 * 16);
    chk("R2", "low clamp", int'(idx_out), 'h80);
    chk("R3", "lowest offset slot", rd_addr[0], 'hF8);
    check_auto("R2");
  endtask

  task automatic t_overflow();
    force_hi = 1'b1;
    run_conv(43 * 16);
    chk("R4", "wrapped result", wr_data[0], 16064);
    chk("R4", "wrapped result ch3", wr_data[3], 16064);
    force_hi = 1'b0;
  endtask

  task automatic t_enables();
    chan_en = 4'b0101;
    run_conv(20 * 16);
    check_auto("R6");
    chan_en = 4'b0000;
    run_conv(21 * 16);
    chk("R9", "no reads when all disabled", rd_n, 0);
    chk("R6", "no writes when all disabled", int'(wr_mask), 0);
    chan_en = 4'hF;
  endtask

  task automatic t_user_idx();
    auto_idx = 1'b0;
    user_idx = 8'h1A;
    chan_en = 4'b0001;
    run_conv(10 * 16);
    chk("R7", "host pointer kept", int'(idx_out), 'h1A);
    chk("R7", "offset from host pointer", rd_addr[0], 'hFD);
    chk("R7", "bit 7 forced", rd_addr[1], 'h9A);
    chk("R7", "host pointer data", wr_data[0], exp_val(0, 'h9A, 'hFD));
    auto_idx = 1'b1;
    chan_en = 4'hF;
  endtask

  task automatic t_busy();
    bus_busy = 1'b1;
    clear_logs();
    pulse_conv(30 * 16);
    repeat (40) @(negedge clk);
    chk("R8", "no reads while busy", rd_n, 0);
    chk("R8", "no done while busy", done_n, 0);
    bus_busy = 1'b0;
    wait_done();
    check_auto("R8");
  endtask

  task automatic t_first_after_reset();
    do_reset();
    run_conv(70 * 16 - 8);
    chk("R5", "first conversion no hysteresis", int'(idx_out), 'h9E);
    check_auto("R5");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_low_band();
    t_high_band_hyst();
    t_clamp();
    t_overflow();
    t_enables();
    t_user_idx();
    t_busy();
    t_first_after_reset();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule